// File: doc/BRIEF.md
# Capturing Reservation Station with Issue Bypass

This block is the operand-holding scheduler in front of one functional unit. Each entry stores a micro-op with the values of its two source operands. At dispatch, a source that the register file already holds arrives as a value. A source that is still being computed arrives as a tag, and the entry snoops the result buses for that tag. All scheduling decisions use only this station's own contents, the incoming dispatch and the result buses.

Each cycle the calculation unit is free, the station sends one micro-op onto the issue bus. The oldest stored entry whose operands are complete goes first. A result that appears on a bus in the same cycle counts as complete and is driven straight onto the issue bus. If no stored entry can go and the micro-op being dispatched has everything it needs, that micro-op is issued in the same cycle and is never written into the station. A flush drops every held entry at once.

Top module: `resv_station`

## Requirements
- R1: After reset the station holds no entry. With the unit free and no dispatch, `iss_valid` is 0 and `disp_stall` is 0.
- R2: When a dispatched source has its ready flag set, its supplied value is used, even if a result bus carries a matching tag. When the flag is clear, the source waits for its tag.
- R3: A stored source that is waiting takes the data of a valid result bus whose tag matches. It keeps that data for later issue.
- R4: A source whose tag matches a valid result bus in the current cycle counts as ready in that cycle, and the bus data appears on the issue bus. This applies to stored entries and to the dispatch.
- R5: Among stored entries that are ready, the one dispatched earliest is issued.
- R6: When the unit is free, no stored entry is ready and the dispatch has both sources ready, the dispatch is issued in the same cycle and is not stored. A ready stored entry takes priority over the dispatch, and the dispatch is then stored.
- R7: While `cu_free` is 0, nothing is issued and the stored entries are kept.
- R8: When all DEPTH entries are held and the dispatch cannot bypass, `disp_stall` is 1 and the dispatch is not stored.
- R9: In a `flush` cycle nothing is issued and the dispatch is dropped. From the next cycle on, the station is empty.
- R10: The issue bus carries the opcode and the destination tag of the chosen micro-op, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Drop all entries and the current dispatch |
| disp_valid | input | 1 | A micro-op is offered this cycle |
| disp_op | input | OP_W | Opcode |
| disp_dst | input | TAG_W | Tag of the result this micro-op will produce |
| disp_a_rdy | input | 1 | Source A value supplied |
| disp_a_tag | input | TAG_W | Source A producer tag |
| disp_a_val | input | DATA_W | Source A value |
| disp_b_rdy | input | 1 | Source B value supplied |
| disp_b_tag | input | TAG_W | Source B producer tag |
| disp_b_val | input | DATA_W | Source B value |
| disp_stall | output | 1 | Dispatch not accepted this cycle |
| res_valid | input | NBUS | Per result bus valid; bus k is bit k |
| res_tag | input | NBUS*TAG_W | Bus k tag at bits k*TAG_W upward |
| res_data | input | NBUS*DATA_W | Bus k data at bits k*DATA_W upward |
| cu_free | input | 1 | Calculation unit accepts a micro-op |
| iss_valid | output | 1 | Issue bus carries a micro-op |
| iss_op | output | OP_W | Issued opcode |
| iss_dst | output | TAG_W | Issued destination tag |
| iss_a | output | DATA_W | Issued source A value |
| iss_b | output | DATA_W | Issued source B value |

## Verification
Two kinds of internal fault show up at the ports. A missed or wrong capture appears on `iss_a` or `iss_b` the first time the affected entry issues, which can be many cycles after the broadcast. A corrupted age order or a lost valid bit appears as the wrong opcode on the issue bus, or as a missing issue, in the first cycle the unit is free. A miscounted occupancy appears as a wrong `disp_stall` in the same cycle as the dispatch. The random phase keeps the unit busy often, so entries wait several cycles between capture and issue.

// File: rtl/resv_station.sv
module resv_station #(
  parameter int DEPTH  = 4,
  parameter int OP_W   = 4,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16,
  parameter int NBUS   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    disp_valid,
  input  logic [OP_W-1:0]         disp_op,
  input  logic [TAG_W-1:0]        disp_dst,
  input  logic                    disp_a_rdy,
  input  logic [TAG_W-1:0]        disp_a_tag,
  input  logic [DATA_W-1:0]       disp_a_val,
  input  logic                    disp_b_rdy,
  input  logic [TAG_W-1:0]        disp_b_tag,
  input  logic [DATA_W-1:0]       disp_b_val,
  output logic                    disp_stall,
  input  logic [NBUS-1:0]         res_valid,
  input  logic [NBUS*TAG_W-1:0]   res_tag,
  input  logic [NBUS*DATA_W-1:0]  res_data,
  input  logic                    cu_free,
  output logic                    iss_valid,
  output logic [OP_W-1:0]         iss_op,
  output logic [TAG_W-1:0]        iss_dst,
  output logic [DATA_W-1:0]       iss_a,
  output logic [DATA_W-1:0]       iss_b
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  function automatic logic bus_hit(input logic [TAG_W-1:0] t);
    bus_hit = 1'b0;
    for (int k = 0; k < NBUS; k++)
      if (res_valid[k] && res_tag[k*TAG_W +: TAG_W] == t) bus_hit = 1'b1;
  endfunction

  function automatic logic [DATA_W-1:0] bus_val(input logic [TAG_W-1:0] t);
    bus_val = '0;
    for (int k = NBUS - 1; k >= 0; k--)
      if (res_valid[k] && res_tag[k*TAG_W +: TAG_W] == t) bus_val = res_data[k*DATA_W +: DATA_W];
  endfunction

  logic [DEPTH-1:0]  vld, n_vld;
  logic [OP_W-1:0]   e_op [DEPTH];
  logic [TAG_W-1:0]  e_dst[DEPTH];
  logic [DEPTH-1:0]  e_ar, e_br;
  logic [TAG_W-1:0]  e_at [DEPTH];
  logic [TAG_W-1:0]  e_bt [DEPTH];
  logic [DATA_W-1:0] e_av [DEPTH];
  logic [DATA_W-1:0] e_bv [DEPTH];

  logic [OP_W-1:0]   n_op [DEPTH];
  logic [TAG_W-1:0]  n_dst[DEPTH];
  logic [DEPTH-1:0]  n_ar, n_br;
  logic [TAG_W-1:0]  n_at [DEPTH];
  logic [TAG_W-1:0]  n_bt [DEPTH];
  logic [DATA_W-1:0] n_av [DEPTH];
  logic [DATA_W-1:0] n_bv [DEPTH];

  logic [DEPTH-1:0]  a_ok, b_ok, rdy;
  logic [DATA_W-1:0] a_cur[DEPTH];
  logic [DATA_W-1:0] b_cur[DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign a_ok[g]  = e_ar[g] | bus_hit(e_at[g]);
    assign b_ok[g]  = e_br[g] | bus_hit(e_bt[g]);
    assign a_cur[g] = e_ar[g] ? e_av[g] : bus_val(e_at[g]);
    assign b_cur[g] = e_br[g] ? e_bv[g] : bus_val(e_bt[g]);
    assign rdy[g]   = vld[g] & a_ok[g] & b_ok[g];
  end

  logic [IW-1:0] sel;
  logic [CW-1:0] cnt;
  always_comb begin
    sel = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (rdy[i]) sel = IW'(i);
    cnt = '0;
    for (int i = 0; i < DEPTH; i++) cnt = cnt + CW'(vld[i]);
  end

  wire               full   = vld[DEPTH-1];
  wire               d_a_ok = disp_a_rdy | bus_hit(disp_a_tag);
  wire               d_b_ok = disp_b_rdy | bus_hit(disp_b_tag);
  wire [DATA_W-1:0]  d_a_v  = disp_a_rdy ? disp_a_val : bus_val(disp_a_tag);
  wire [DATA_W-1:0]  d_b_v  = disp_b_rdy ? disp_b_val : bus_val(disp_b_tag);
  wire               take   = !flush && cu_free && (|rdy);
  wire               byp    = !flush && cu_free && !(|rdy) && disp_valid && d_a_ok && d_b_ok;
  wire               store  = !flush && disp_valid && !byp && !full;
  wire [CW-1:0]      pos    = cnt - CW'(take);

  assign disp_stall = disp_valid && full && !byp;
  assign iss_valid  = take | byp;
  assign iss_op     = take ? e_op[sel]  : disp_op;
  assign iss_dst    = take ? e_dst[sel] : disp_dst;
  assign iss_a      = take ? a_cur[sel] : d_a_v;
  assign iss_b      = take ? b_cur[sel] : d_b_v;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      int src;
      src = (take && i >= int'(sel)) ? i + 1 : i;
      n_vld[i] = 1'b0;
      n_op[i]  = e_op[i];
      n_dst[i] = e_dst[i];
      n_ar[i]  = e_ar[i];
      n_br[i]  = e_br[i];
      n_at[i]  = e_at[i];
      n_bt[i]  = e_bt[i];
      n_av[i]  = e_av[i];
      n_bv[i]  = e_bv[i];
      if (!flush) begin
        if (src < DEPTH && vld[src]) begin
          n_vld[i] = 1'b1;
          n_op[i]  = e_op[src];
          n_dst[i] = e_dst[src];
          n_ar[i]  = a_ok[src];
          n_br[i]  = b_ok[src];
          n_at[i]  = e_at[src];
          n_bt[i]  = e_bt[src];
          n_av[i]  = a_cur[src];
          n_bv[i]  = b_cur[src];
        end else if (store && i == int'(pos)) begin
          n_vld[i] = 1'b1;
          n_op[i]  = disp_op;
          n_dst[i] = disp_dst;
          n_ar[i]  = d_a_ok;
          n_br[i]  = d_b_ok;
          n_at[i]  = disp_a_tag;
          n_bt[i]  = disp_b_tag;
          n_av[i]  = d_a_v;
          n_bv[i]  = d_b_v;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) vld <= '0;
    else        vld <= n_vld;

  always_ff @(posedge clk) begin
    e_ar <= n_ar;
    e_br <= n_br;
    for (int i = 0; i < DEPTH; i++) begin
      e_op[i]  <= n_op[i];
      e_dst[i] <= n_dst[i];
      e_at[i]  <= n_at[i];
      e_bt[i]  <= n_bt[i];
      e_av[i]  <= n_av[i];
      e_bv[i]  <= n_bv[i];
    end
  end
endmodule

// File: rtl/resv_station_chk.sv
module resv_station_chk #(
  parameter int DEPTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             cu_free,
  input logic             disp_valid,
  input logic             disp_stall,
  input logic             iss_valid,
  input logic [DEPTH-1:0] vld,
  input logic             byp
);
  a_r7_unit_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !cu_free |-> !iss_valid);

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld == '0));

  a_r9_flush_silent: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !iss_valid);

  a_r8_stall_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    disp_stall |-> (&vld));

  a_r8_stall_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    disp_stall |=> $countones(vld) <= $past($countones(vld)));

  a_r6_bypass_not_kept: assert property (@(posedge clk) disable iff (!rst_n)
    byp |=> $countones(vld) <= $past($countones(vld)));

  a_r1_issue_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> ((|vld) || disp_valid));

  a_r5_packed_age: assert property (@(posedge clk) disable iff (!rst_n)
    (vld & (vld + 1'b1)) == '0);
endmodule

bind resv_station resv_station_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .cu_free(cu_free),
  .disp_valid(disp_valid), .disp_stall(disp_stall), .iss_valid(iss_valid),
  .vld(vld), .byp(byp)
);

// File: tb/sim_resv_station.sv
module sim_resv_station;
  localparam int DEPTH = 4, OP_W = 4, TAG_W = 4, DATA_W = 16, NBUS = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, flush, disp_valid, disp_a_rdy, disp_b_rdy, cu_free;
  logic [OP_W-1:0] disp_op;
  logic [TAG_W-1:0] disp_dst, disp_a_tag, disp_b_tag;
  logic [DATA_W-1:0] disp_a_val, disp_b_val;
  logic [NBUS-1:0] res_valid;
  logic [NBUS*TAG_W-1:0] res_tag;
  logic [NBUS*DATA_W-1:0] res_data;
  logic disp_stall, iss_valid;
  logic [OP_W-1:0] iss_op;
  logic [TAG_W-1:0] iss_dst;
  logic [DATA_W-1:0] iss_a, iss_b;

  resv_station #(.DEPTH(DEPTH), .OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .NBUS(NBUS)) u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .disp_valid(disp_valid), .disp_op(disp_op),
    .disp_dst(disp_dst), .disp_a_rdy(disp_a_rdy), .disp_a_tag(disp_a_tag), .disp_a_val(disp_a_val),
    .disp_b_rdy(disp_b_rdy), .disp_b_tag(disp_b_tag), .disp_b_val(disp_b_val), .disp_stall(disp_stall),
    .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data), .cu_free(cu_free),
    .iss_valid(iss_valid), .iss_op(iss_op), .iss_dst(iss_dst), .iss_a(iss_a), .iss_b(iss_b));

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  typedef struct {
    logic [OP_W-1:0] op; logic [TAG_W-1:0] dst;
    bit ar, br; logic [TAG_W-1:0] at, bt; logic [DATA_W-1:0] av, bv;
  } ent_t;
  ent_t q[$];

  function automatic bit mhit(input logic [TAG_W-1:0] t);
    for (int k = 0; k < NBUS; k++)
      if (res_valid[k] && res_tag[k*TAG_W +: TAG_W] == t) return 1;
    return 0;
  endfunction

  function automatic logic [DATA_W-1:0] mval(input logic [TAG_W-1:0] t);
    for (int k = 0; k < NBUS; k++)
      if (res_valid[k] && res_tag[k*TAG_W +: TAG_W] == t) return res_data[k*DATA_W +: DATA_W];
    return '0;
  endfunction

  function automatic ent_t grab(input ent_t e);
    ent_t r = e;
    if (!r.ar && mhit(r.at)) begin r.ar = 1; r.av = mval(r.at); end
    if (!r.br && mhit(r.bt)) begin r.br = 1; r.bv = mval(r.bt); end
    return r;
  endfunction

  function automatic ent_t incoming();
    ent_t e;
    e.op = disp_op; e.dst = disp_dst;
    e.ar = disp_a_rdy; e.at = disp_a_tag; e.av = disp_a_val;
    e.br = disp_b_rdy; e.bt = disp_b_tag; e.bv = disp_b_val;
    return grab(e);
  endfunction

  function automatic int oldest_ready();
    for (int i = 0; i < q.size(); i++) begin
      ent_t c = grab(q[i]);
      if (c.ar && c.br) return i;
    end
    return -1;
  endfunction

  function automatic bit bypass_now();
    ent_t d = incoming();
    return !flush && cu_free && oldest_ready() < 0 && disp_valid && d.ar && d.br;
  endfunction

  task automatic compare();
    int k = oldest_ready();
    bit byp = bypass_now();
    bit ev = (!flush && cu_free && k >= 0) || byp;
    bit est = disp_valid && q.size() == DEPTH && !byp;
    ent_t e = (ev && !byp) ? grab(q[k]) : incoming();
    chk(iss_valid == ev, "R5 issue valid", iss_valid, ev);
    if (ev && iss_valid) begin
      chk(iss_op == e.op, "R10 opcode", iss_op, e.op);
      chk(iss_dst == e.dst, "R10 dest tag", iss_dst, e.dst);
      chk(iss_a == e.av, "R4 operand A", iss_a, e.av);
      chk(iss_b == e.bv, "R4 operand B", iss_b, e.bv);
    end
    chk(disp_stall == est, "R8 stall", disp_stall, est);
  endtask

  task automatic commit();
    int k = oldest_ready();
    bit byp = bypass_now();
    int sz0 = q.size();
    ent_t d = incoming();
    if (flush) begin q.delete(); return; end
    foreach (q[i]) q[i] = grab(q[i]);
    if (cu_free && k >= 0) q.delete(k);
    if (disp_valid && !byp && sz0 < DEPTH) q.push_back(d);
  endtask

  task automatic step();
    #1 compare();
    @(posedge clk);
    commit();
    @(negedge clk);
  endtask

  task automatic idle();
    flush = 0; disp_valid = 0; disp_op = '0; disp_dst = '0;
    disp_a_rdy = 0; disp_a_tag = '0; disp_a_val = '0;
    disp_b_rdy = 0; disp_b_tag = '0; disp_b_val = '0;
    res_valid = '0; res_tag = '0; res_data = '0; cu_free = 0;
  endtask

  task automatic put(input int op, input int dst, input bit ar, input int at, input int av,
                     input bit br, input int bt, input int bv);
    disp_valid = 1; disp_op = OP_W'(op); disp_dst = TAG_W'(dst);
    disp_a_rdy = ar; disp_a_tag = TAG_W'(at); disp_a_val = DATA_W'(av);
    disp_b_rdy = br; disp_b_tag = TAG_W'(bt); disp_b_val = DATA_W'(bv);
  endtask

  task automatic bus(input int k, input int tag, input int data);
    res_valid[k] = 1'b1;
    res_tag[k*TAG_W +: TAG_W] = TAG_W'(tag);
    res_data[k*DATA_W +: DATA_W] = DATA_W'(data);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cu_free = 1;
    #1 chk(iss_valid == 0, "R1 reset no issue", iss_valid, 0);
    chk(disp_stall == 0, "R1 reset no stall", disp_stall, 0);
    step();

    // fill with waiting A operands (tags 1..4)
    cu_free = 0;
    for (int i = 0; i < DEPTH; i++) begin
      put(i + 1, i + 8, 0, i + 1, 0, 1, 0, 100 + i);
      step();
    end
    put(5, 12, 0, 5, 0, 1, 0, 500);
    #1 chk(disp_stall == 1, "R8 stall when full", disp_stall, 1);
    step();

    idle(); cu_free = 1;
    bus(0, 3, 333); bus(1, 1, 111);
    #1 chk(iss_op == 1, "R5 oldest first", iss_op, 1);
    chk(iss_a == 111, "R4 forwarded value", iss_a, 111);
    step();

    idle(); cu_free = 1;
    #1 chk(iss_valid == 1 && iss_op == 3, "R3 captured entry issues", iss_op, 3);
    chk(iss_a == 333, "R3 captured value", iss_a, 333);
    step();

    idle(); cu_free = 0; bus(0, 2, 222);
    #1 chk(iss_valid == 0, "R7 unit busy", iss_valid, 0);
    step();
    idle(); cu_free = 1;
    #1 chk(iss_valid == 1 && iss_op == 2, "R7 entry kept", iss_op, 2);
    cu_free = 0;
    step();

    idle(); flush = 1; cu_free = 1; bus(0, 4, 444);
    #1 chk(iss_valid == 0, "R9 flush no issue", iss_valid, 0);
    step();
    idle(); cu_free = 1; bus(0, 4, 444); bus(1, 5, 555);
    #1 chk(iss_valid == 0, "R9 station empty after flush", iss_valid, 0);
    step();

    idle(); cu_free = 1;
    put(7, 9, 1, 6, 16'h1234, 0, 6, 0);
    bus(0, 6, 16'h5555);
    #1 chk(iss_valid == 1 && iss_op == 7, "R6 bypass issue", iss_op, 7);
    chk(iss_a == 16'h1234, "R2 supplied value wins", iss_a, 16'h1234);
    chk(iss_b == 16'h5555, "R4 dispatch forward", iss_b, 16'h5555);
    chk(iss_dst == 9, "R10 dest tag", iss_dst, 9);
    step();
    idle(); cu_free = 1;
    #1 chk(iss_valid == 0, "R6 bypass not stored", iss_valid, 0);
    step();

    idle(); put(10, 1, 1, 0, 10, 1, 0, 20);
    step();
    idle(); cu_free = 1; put(11, 2, 1, 0, 30, 1, 0, 40);
    #1 chk(iss_op == 10, "R6 stored ready entry wins", iss_op, 10);
    step();
    idle(); cu_free = 1;
    #1 chk(iss_valid == 1 && iss_op == 11, "R6 losing dispatch stored", iss_op, 11);
    step();

    for (int n = 0; n < 4000; n++) begin
      int t0, t1;
      idle();
      flush = (($urandom % 50) == 0);
      cu_free = (($urandom % 10) < 6);
      if (($urandom % 10) < 6)
        put($urandom % 16, $urandom % 16, ($urandom % 2) == 0, $urandom % 8, $urandom,
            ($urandom % 2) == 0, $urandom % 8, $urandom);
      t0 = $urandom % 8;
      t1 = (t0 + 1 + ($urandom % 7)) % 8;
      if (($urandom % 3) != 0) bus(0, t0, $urandom);
      if (($urandom % 3) == 0) bus(1, t1, $urandom);
      step();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule